// File: doc/BRIEF.md
# Three-Bit Status Link Receiver

This block receives a 3-bit status code from a remote reporting unit and answers on a 3-bit return path. The input is asynchronous, so it first passes through a synchronizer. It then goes through a stability filter, and after that a run-length meter times how long the all-ones code is held. A short all-ones hold opens a one-shot transfer window. A long all-ones hold is a request to shut down after the current cycle. The same code value therefore carries two commands, and only its duration tells them apart.

Inside an open window, the first data code (001 to 110) is captured. It appears as a cleanliness grade from 1 (cleanest) to 6 (dirtiest), together with a single-cycle strobe. The return path then drives 111 as a receipt and keeps driving it until the sender drops back to 000. After that the block goes idle again.

Data codes that arrive while no window is open are dropped, and each one is counted. The shutdown request is held as a sticky flag until it is cleared.

Top module: `statlink_rx`

## Requirements
- R1: After reset, linkOut is 000, gradeValid is 0, shutdownReq is 0 and errCount is 0.
- R2: A 111 hold with a filtered length from SHORT_MIN up to LONG_MIN-1 cycles opens a transfer window. The window takes effect only if the sender moves directly from 111 to a data code.
- R3: Inside a window, a filtered data code 001..110 is reported on grade as the same binary value, 1..6, with gradeValid high for exactly one cycle.
- R4: linkOut is 111 from the cycle in which gradeValid rises until the filtered input returns to 000. At all other times linkOut is 000, so only the values 000 and 111 ever appear.
- R5: A filtered 000 closes a window or receipt. A data code that follows without a fresh short 111 produces no grade.
- R6: A data code that becomes the filtered input while no window is open produces no grade. It also adds one to errCount (saturating at its maximum).
- R7: A 111 hold shorter than SHORT_MIN filtered cycles neither opens a window nor sets shutdownReq.
- R8: A 111 hold of at least LONG_MIN filtered cycles sets shutdownReq when the hold ends. It does not open a window.
- R9: shutdownReq stays set until clrShutdown is high. If a new request and a clear arrive in the same cycle, the request wins.
- R10: A code that stays at the synchronizer output for fewer than STABLE_CYC cycles is never taken as the filtered input. It neither breaks a 111 hold nor gets captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| linkIn | input | 3 | Asynchronous status code from the remote sender |
| clrShutdown | input | 1 | Clears the sticky shutdown request |
| linkOut | output | 3 | Return code: 000 when idle, 111 as receipt |
| grade | output | 3 | Captured cleanliness grade, 1..6 |
| gradeValid | output | 1 | One-cycle strobe marking a new grade |
| shutdownReq | output | 1 | Sticky shutdown-after-cycle request |
| errCount | output | ERR_W | Count of data codes received outside a window |

## Verification
If the control state is wrong, the first place it shows is the return path. A receipt that is lost or stuck shows on linkOut within about ten cycles of the sender changing code. That delay comes from the synchronizer and the filter.

If the run-length meter misclassifies a hold, the effect appears when the hold ends. Either a grade goes missing from the scoreboard queue, or errCount or shutdownReq moves against the bench's own tally.

If the filter is too permissive, a short blip replaces the expected grade. The scoreboard reports this as a value mismatch rather than a missing item.

// File: rtl/statlink_pkg.sv
package statlink_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STANDBY = 2'd1,
    ST_ACK     = 2'd2
  } linkState_e;

  typedef struct packed {
    logic captureGrade;
    logic bumpError;
    logic setShutdown;
  } ctrlStrobe_t;

  localparam logic [2:0] CODE_NULL = 3'b000;
  localparam logic [2:0] CODE_ONES = 3'b111;

  function automatic logic isData(input logic [2:0] code);
    return (code != CODE_NULL) && (code != CODE_ONES);
  endfunction

endpackage

// File: rtl/statlink_dp.sv
module statlink_dp
  import statlink_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int SHORT_MIN   = 8,
  parameter int LONG_MIN    = 64,
  parameter int ERR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       linkIn,
  input  logic             clrShutdown,
  input  ctrlStrobe_t      strobe,
  output logic [2:0]       filtCode,
  output logic [2:0]       nextCode,
  output logic             loadFilt,
  output logic             shortDone,
  output logic             longDone,
  output logic [2:0]       grade,
  output logic             gradeValid,
  output logic             shutdownReq,
  output logic [ERR_W-1:0] errCount
);

  localparam int STAB_W = $clog2(STABLE_CYC + 1);
  localparam int RUN_W  = $clog2(LONG_MIN + 1);
  localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(STABLE_CYC - 1);
  localparam logic [RUN_W-1:0]  RUN_SHORT = RUN_W'(SHORT_MIN);
  localparam logic [RUN_W-1:0]  RUN_LONG  = RUN_W'(LONG_MIN);
  localparam logic [ERR_W-1:0]  ERR_MAX   = '1;

  // synchronizer chain
  logic [2:0] syncStage [SYNC_STAGES];
  generate
    for (genvar gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncStage[gi] <= CODE_NULL;
        else if (gi == 0) syncStage[gi] <= linkIn;
        else syncStage[gi] <= syncStage[(gi == 0) ? 0 : gi - 1];
      end
    end
  endgenerate

  logic [2:0] inSync;
  assign inSync = syncStage[SYNC_STAGES-1];

  // stability filter
  logic [2:0]        candCode;
  logic [STAB_W-1:0] stabCnt;

  assign nextCode = candCode;
  assign loadFilt = (inSync == candCode) && (stabCnt == STAB_LAST)
                    && (filtCode != candCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candCode <= CODE_NULL;
      stabCnt  <= '0;
      filtCode <= CODE_NULL;
    end else if (inSync != candCode) begin
      candCode <= inSync;
      stabCnt  <= '0;
    end else if (stabCnt != STAB_LAST) begin
      stabCnt <= stabCnt + 1'b1;
    end else if (loadFilt) begin
      filtCode <= candCode;
    end
  end

  // all-ones run-length meter
  logic [RUN_W-1:0] onesRun;
  logic             leavingOnes;

  assign leavingOnes = loadFilt && (filtCode == CODE_ONES);
  assign shortDone   = leavingOnes && (onesRun >= RUN_SHORT) && (onesRun < RUN_LONG);
  assign longDone    = leavingOnes && (onesRun >= RUN_LONG);

  always_ff @(posedge clk) begin
    if (!rstN || loadFilt) onesRun <= '0;
    else if (filtCode == CODE_ONES && onesRun != RUN_LONG) onesRun <= onesRun + 1'b1;
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grade       <= CODE_NULL;
      gradeValid  <= 1'b0;
      shutdownReq <= 1'b0;
      errCount    <= '0;
    end else begin
      gradeValid <= strobe.captureGrade;
      if (strobe.captureGrade) grade <= filtCode;
      if (strobe.setShutdown) shutdownReq <= 1'b1;
      else if (clrShutdown) shutdownReq <= 1'b0;
      if (strobe.bumpError && errCount != ERR_MAX) errCount <= errCount + 1'b1;
    end
  end

endmodule

// File: rtl/statlink_ctrl.sv
module statlink_ctrl
  import statlink_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  filtCode,
  input  logic [2:0]  nextCode,
  input  logic        loadFilt,
  input  logic        shortDone,
  input  logic        longDone,
  output ctrlStrobe_t strobe,
  output logic        ackActive
);

  linkState_e state, stateNext;

  always_comb begin
    stateNext           = state;
    strobe              = '0;
    strobe.setShutdown  = longDone;
    unique case (state)
      ST_IDLE: begin
        if (shortDone) stateNext = ST_STANDBY;
        else if (loadFilt && isData(nextCode)) strobe.bumpError = 1'b1;
      end
      ST_STANDBY: begin
        if (isData(filtCode)) begin
          strobe.captureGrade = 1'b1;
          stateNext           = ST_ACK;
        end else if (filtCode == CODE_NULL) begin
          stateNext = ST_IDLE;
        end
      end
      ST_ACK: begin
        if (filtCode == CODE_NULL) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign ackActive = (state == ST_ACK);

endmodule

// File: rtl/statlink_rx.sv
module statlink_rx
  import statlink_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CYC  = 4,
  parameter int SHORT_MIN   = 8,
  parameter int LONG_MIN    = 64,
  parameter int ERR_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       linkIn,
  input  logic             clrShutdown,
  output logic [2:0]       linkOut,
  output logic [2:0]       grade,
  output logic             gradeValid,
  output logic             shutdownReq,
  output logic [ERR_W-1:0] errCount
);

  ctrlStrobe_t strobe;
  logic [2:0]  filtCode, nextCode;
  logic        loadFilt, shortDone, longDone, ackActive;

  statlink_dp #(
    .SYNC_STAGES(SYNC_STAGES), .STABLE_CYC(STABLE_CYC),
    .SHORT_MIN(SHORT_MIN), .LONG_MIN(LONG_MIN), .ERR_W(ERR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .clrShutdown(clrShutdown),
    .strobe(strobe), .filtCode(filtCode), .nextCode(nextCode),
    .loadFilt(loadFilt), .shortDone(shortDone), .longDone(longDone),
    .grade(grade), .gradeValid(gradeValid), .shutdownReq(shutdownReq),
    .errCount(errCount)
  );

  statlink_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .filtCode(filtCode), .nextCode(nextCode),
    .loadFilt(loadFilt), .shortDone(shortDone), .longDone(longDone),
    .strobe(strobe), .ackActive(ackActive)
  );

  assign linkOut = ackActive ? CODE_ONES : CODE_NULL;

endmodule

// File: rtl/statlink_rx_chk.sv
module statlink_rx_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             clrShutdown,
  input logic [2:0]       linkOut,
  input logic [2:0]       grade,
  input logic             gradeValid,
  input logic             shutdownReq,
  input logic [ERR_W-1:0] errCount
);

  p_ack_with_grade_r4: assert property (@(posedge clk) disable iff (!rstN)
    gradeValid |-> linkOut == 3'b111);

  p_out_codes_r4: assert property (@(posedge clk) disable iff (!rstN)
    linkOut == 3'b000 || linkOut == 3'b111);

  p_grade_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    gradeValid |-> (grade != 3'b000 && grade != 3'b111));

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    gradeValid |=> !gradeValid);

  p_shutdown_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownReq && !clrShutdown) |=> shutdownReq);

  p_err_no_decrease_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) or 1'b1 |=> errCount >= $past(errCount));

endmodule

bind statlink_rx statlink_rx_chk #(.ERR_W(ERR_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrShutdown(clrShutdown), .linkOut(linkOut),
  .grade(grade), .gradeValid(gradeValid), .shutdownReq(shutdownReq),
  .errCount(errCount)
);

// File: tb/tb_statlink_rx.sv
module tb_statlink_rx;

  localparam int ERR_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       linkIn = 3'b000;
  logic             clrShutdown = 1'b0;
  logic [2:0]       linkOut, grade;
  logic             gradeValid, shutdownReq;
  logic [ERR_W-1:0] errCount;

  int nCheck = 0;
  int nFail  = 0;
  int expErr = 0;
  logic [2:0] expQ [$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  statlink_rx #(.ERR_W(ERR_W)) dut (
    .clk(clk), .rstN(rstN), .linkIn(linkIn), .clrShutdown(clrShutdown),
    .linkOut(linkOut), .grade(grade), .gradeValid(gradeValid),
    .shutdownReq(shutdownReq), .errCount(errCount)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [2:0] code, input int cycles);
    linkIn = code;
    repeat (cycles) @(negedge clk);
  endtask

  // driver for a complete transfer: the grade is queued for the monitor
  task automatic transfer(input logic [2:0] g);
    expQ.push_back(g);
    hold(3'b111, 20);
    hold(g, 20);
    check(linkOut == 3'b111, "R4 receipt held", linkOut, 7);
    hold(3'b000, 20);
    check(linkOut == 3'b000, "R5 receipt released", linkOut, 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && gradeValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 unexpected grade", grade, 0);
      end else begin
        automatic logic [2:0] e = expQ.pop_front();
        check(grade == e, "R3 grade value", grade, e);
        check(linkOut == 3'b111, "R4 receipt with grade", linkOut, 7);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(linkOut == 0, "R1 linkOut", linkOut, 0);
    check(gradeValid == 0, "R1 gradeValid", gradeValid, 0);
    check(shutdownReq == 0, "R1 shutdownReq", shutdownReq, 0);
    check(errCount == 0, "R1 errCount", errCount, 0);

    // R2 R3: every grade through a short window
    for (int g = 1; g <= 6; g++) transfer(3'(g));

    // R6: data outside a window
    hold(3'b010, 30);
    expErr++;
    check(errCount == ERR_W'(expErr), "R6 error count", errCount, expErr);
    check(linkOut == 0, "R6 no receipt", linkOut, 0);
    hold(3'b000, 20);

    // R7: brief all-ones hold is a glitch
    hold(3'b111, 5);
    hold(3'b011, 30);
    expErr++;
    check(errCount == ERR_W'(expErr), "R7 glitch no window", errCount, expErr);
    check(shutdownReq == 0, "R7 no shutdown", shutdownReq, 0);
    hold(3'b000, 20);

    // R5: null closes an open window
    hold(3'b111, 20);
    hold(3'b000, 20);
    hold(3'b101, 30);
    expErr++;
    check(errCount == ERR_W'(expErr), "R5 window closed", errCount, expErr);
    hold(3'b000, 20);

    // R10: blip inside an all-ones hold is filtered out
    expQ.push_back(3'b100);
    hold(3'b111, 12);
    hold(3'b101, 2);
    hold(3'b111, 12);
    hold(3'b100, 20);
    check(linkOut == 3'b111, "R10 receipt after blip", linkOut, 7);
    hold(3'b000, 20);

    // R8: long hold requests shutdown, no window
    hold(3'b111, 100);
    hold(3'b010, 30);
    expErr++;
    check(shutdownReq == 1, "R8 shutdown set", shutdownReq, 1);
    check(errCount == ERR_W'(expErr), "R8 no window", errCount, expErr);
    hold(3'b000, 20);

    // R9: sticky across traffic, then cleared
    transfer(3'b110);
    check(shutdownReq == 1, "R9 sticky", shutdownReq, 1);
    clrShutdown = 1'b1;
    @(negedge clk);
    clrShutdown = 1'b0;
    @(negedge clk);
    check(shutdownReq == 0, "R9 cleared", shutdownReq, 0);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3 all grades seen", expQ.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule